// File: doc/BRIEF.md
# Reset and Fail-Safe Supervisor

This block drives the low-true reset and halt lines of a module's processor core and holds a fail-safe latch that protects the rest of the module. It stretches a reset in three cases: when the module powers up, when an external reset request arrives, and when the logic supplies fall out of specification. A supply-in-spec flag comes from an analog monitor outside this block. While that flag is low, reset and halt stay asserted. Once the flag returns, they stay asserted for a stretch of 130 ms, counted in core clock cycles from a clock-frequency parameter. An external reset keeps them asserted for at least 24 clocks after the request drops.

The processor's watchdog gives a low-true strobe. Once the processor has left reset, this strobe sets a sticky fail-safe flag. Only a loss of supply, which leads to a fresh power-on, or an external reset clears that flag. While the flag is set, the serial transmitter is inhibited and the isolated supply converter is shut down. At other times the converter shutdown follows the processor's low-true request to power the isolated side, and that request counts as inactive while the processor is held in reset. The block also produces a square-wave synchronisation reference for the converter, divided down from the core clock.

Top module: `rst_failsafe_sup`

## Requirements
- R1: After power is applied, `rst_n` is low and `failsafe` is 0. Once `supply_ok` has been sampled high on STRETCH_CYC consecutive rising edges (STRETCH_CYC = CLK_HZ/1000*STRETCH_MS), `rst_n` stays low through that edge and goes high on the following edge.
- R2: If `supply_ok` is sampled low, `rst_n` is low after that same edge. When `supply_ok` returns, the R1 stretch restarts from zero.
- R3: If `ext_rst` is sampled high, `rst_n` is low after that edge. After `ext_rst` drops, `rst_n` stays low for EXT_MIN_CYC more rising edges and goes high on the next edge.
- R4: `halt_n` equals `rst_n` on every cycle.
- R5: A low `wdog_n`, sampled while `rst_n` is high, sets `failsafe` on that same edge.
- R6: `failsafe` stays set until `ext_rst` is sampled high or `supply_ok` is sampled low. Either of these clears it on that edge, and the clear takes priority over a set.
- R7: While `failsafe` is 1, `tx_inhibit` is 1 and `conv_off` is 1, whatever the value of `iso_req_n`.
- R8: When `failsafe` is 0 and `rst_n` is high, `conv_off` equals `iso_req_n`. While `rst_n` is low, `conv_off` is 1.
- R9: A low `wdog_n` on the edge where `rst_n` rises is ignored, so `failsafe` stays 0.
- R10: `conv_sync` is a square wave with period 2*(CLK_HZ/SYNC_HZ/2) clocks that is high for half of that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| supply_ok | input | 1 | All logic supplies within specification |
| ext_rst | input | 1 | External reset request, high true |
| wdog_n | input | 1 | Processor watchdog strobe, low true |
| iso_req_n | input | 1 | Processor request to power the isolated supply, low true |
| rst_n | output | 1 | Processor reset, low true |
| halt_n | output | 1 | Processor halt, low true |
| failsafe | output | 1 | Fail-safe latch state |
| tx_inhibit | output | 1 | Serial transmitter disable |
| conv_off | output | 1 | Isolated converter shutdown |
| conv_sync | output | 1 | Converter synchronisation reference |

## Verification
Inputs change on falling edges. Reset and fail-safe results are registered, so each is checked at the first falling edge after the rising edge that samples the stimulus. A supply drop, an external reset or a watchdog strobe therefore shows one falling edge later. The end of a stretch is checked on both sides of the boundary: `rst_n` must still be low after STRETCH_CYC (or EXT_MIN_CYC+1) edges and must be high one edge later. `conv_off` is combinational from the request, so it is checked at the same falling edge where the request changes. `conv_sync` is checked by counting falling edges between its transitions.

// File: rtl/rst_failsafe_sup.sv
module rst_failsafe_sup #(
  parameter int CLK_HZ      = 9_869_000,
  parameter int STRETCH_MS  = 130,
  parameter int EXT_MIN_CYC = 24,
  parameter int SYNC_HZ     = 200_000
) (
  input  logic clk,
  input  logic supply_ok,
  input  logic ext_rst,
  input  logic wdog_n,
  input  logic iso_req_n,
  output logic rst_n,
  output logic halt_n,
  output logic failsafe,
  output logic tx_inhibit,
  output logic conv_off,
  output logic conv_sync
);
  localparam int STRETCH_CYC = (CLK_HZ / 1000) * STRETCH_MS;
  localparam int PW = $clog2(STRETCH_CYC + 1);
  localparam int EW = $clog2(EXT_MIN_CYC + 1);
  localparam int HALF = (CLK_HZ / SYNC_HZ / 2 < 1) ? 1 : CLK_HZ / SYNC_HZ / 2;
  localparam int SW = (HALF < 2) ? 1 : $clog2(HALF);
  localparam logic [PW-1:0] PMAX = PW'(STRETCH_CYC);
  localparam logic [EW-1:0] EMAX = EW'(EXT_MIN_CYC);
  localparam logic [SW-1:0] SMAX = SW'(HALF - 1);

  logic [PW-1:0] pwr_cnt = '0;
  logic [EW-1:0] ext_cnt = EMAX;
  logic [SW-1:0] sync_cnt = '0;
  logic          run_q = 1'b0;
  logic          fs_q = 1'b0;
  logic          sync_q = 1'b0;

  always_ff @(posedge clk) begin
    if (!supply_ok)          pwr_cnt <= '0;
    else if (pwr_cnt != PMAX) pwr_cnt <= pwr_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ext_rst)             ext_cnt <= '0;
    else if (ext_cnt != EMAX) ext_cnt <= ext_cnt + 1'b1;
  end

  always_ff @(posedge clk)
    run_q <= supply_ok && !ext_rst && (pwr_cnt == PMAX) && (ext_cnt == EMAX);

  always_ff @(posedge clk) begin
    if (!supply_ok || ext_rst)  fs_q <= 1'b0;
    else if (run_q && !wdog_n)  fs_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (sync_cnt == SMAX) begin
      sync_cnt <= '0;
      sync_q   <= !sync_q;
    end else begin
      sync_cnt <= sync_cnt + 1'b1;
    end
  end

  assign rst_n      = run_q;
  assign halt_n     = run_q;
  assign failsafe   = fs_q;
  assign tx_inhibit = fs_q;
  assign conv_off   = fs_q | iso_req_n | !run_q;
  assign conv_sync  = sync_q;
endmodule

// File: rtl/rst_failsafe_sup_chk.sv
module rst_failsafe_sup_chk #(
  parameter int CLK_HZ      = 9_869_000,
  parameter int STRETCH_MS  = 130,
  parameter int EXT_MIN_CYC = 24
) (
  input logic clk,
  input logic supply_ok,
  input logic ext_rst,
  input logic wdog_n,
  input logic iso_req_n,
  input logic rst_n,
  input logic halt_n,
  input logic failsafe,
  input logic tx_inhibit,
  input logic conv_off
);
  localparam int S = (CLK_HZ / 1000) * STRETCH_MS;
  int unsigned sup_age = 0;
  int unsigned ext_age = EXT_MIN_CYC;

  always_ff @(posedge clk) begin
    if (!supply_ok)   sup_age <= 0;
    else if (sup_age < S) sup_age <= sup_age + 1;
    if (ext_rst)      ext_age <= 0;
    else if (ext_age < EXT_MIN_CYC) ext_age <= ext_age + 1;
  end

  AST_SUPPLY_STRETCH: assert property (@(posedge clk) disable iff (ext_rst)
    (!supply_ok || sup_age < S) |=> !rst_n); // R2
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!supply_ok)
    (ext_rst || ext_age < EXT_MIN_CYC) |=> !rst_n); // R3
  AST_HALT_TRACKS: assert property (@(posedge clk) disable iff (ext_rst)
    halt_n == rst_n); // R4
  AST_WDOG_SETS: assert property (@(posedge clk) disable iff (!supply_ok)
    (rst_n && !wdog_n && !ext_rst) |=> failsafe); // R5
  AST_FS_STICKY: assert property (@(posedge clk) disable iff (!supply_ok)
    (failsafe && !ext_rst) |=> failsafe); // R6
  AST_FS_GATES: assert property (@(posedge clk) disable iff (ext_rst)
    failsafe |-> (conv_off && tx_inhibit)); // R7
  AST_RESET_CONV_OFF: assert property (@(posedge clk) disable iff (ext_rst)
    !rst_n |-> conv_off); // R8
endmodule

bind rst_failsafe_sup rst_failsafe_sup_chk #(
  .CLK_HZ(CLK_HZ), .STRETCH_MS(STRETCH_MS), .EXT_MIN_CYC(EXT_MIN_CYC)
) u_chk (
  .clk(clk), .supply_ok(supply_ok), .ext_rst(ext_rst), .wdog_n(wdog_n),
  .iso_req_n(iso_req_n), .rst_n(rst_n), .halt_n(halt_n), .failsafe(failsafe),
  .tx_inhibit(tx_inhibit), .conv_off(conv_off)
);

// File: tb/tb_rst_failsafe_sup.sv
module tb_rst_failsafe_sup;
  localparam int CLK_HZ = 100_000;
  localparam int STRETCH_MS = 130;
  localparam int EXT = 24;
  localparam int SYNC_HZ = 10_000;
  localparam int S = (CLK_HZ / 1000) * STRETCH_MS;
  localparam int HALF = CLK_HZ / SYNC_HZ / 2;

  logic clk = 1'b0;
  logic supply_ok = 1'b0, ext_rst = 1'b0, wdog_n = 1'b1, iso_req_n = 1'b1;
  logic rst_n, halt_n, failsafe, tx_inhibit, conv_off, conv_sync;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  rst_failsafe_sup #(.CLK_HZ(CLK_HZ), .STRETCH_MS(STRETCH_MS),
    .EXT_MIN_CYC(EXT), .SYNC_HZ(SYNC_HZ)) dut (
    .clk(clk), .supply_ok(supply_ok), .ext_rst(ext_rst), .wdog_n(wdog_n),
    .iso_req_n(iso_req_n), .rst_n(rst_n), .halt_n(halt_n), .failsafe(failsafe),
    .tx_inhibit(tx_inhibit), .conv_off(conv_off), .conv_sync(conv_sync));

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_powerup;
    step(3);
    check("R1 reset at power-up", rst_n, 0);
    check("R1 failsafe at power-up", failsafe, 0);
    check("R8 conv_off in reset", conv_off, 1);
    supply_ok = 1'b1;
    step(S);
    check("R1 still low at stretch end", rst_n, 0);
    step(1);
    check("R1 released", rst_n, 1);
    check("R4 halt follows", halt_n, 1);
  endtask

  task automatic t_conv_req;
    iso_req_n = 1'b0; step(1);
    check("R8 conv on by request", conv_off, 0);
    iso_req_n = 1'b1; step(1);
    check("R8 conv off by request", conv_off, 1);
  endtask

  task automatic t_ext_reset;
    iso_req_n = 1'b0;
    ext_rst = 1'b1; step(1);
    check("R3 ext asserts", rst_n, 0);
    check("R4 halt asserts", halt_n, 0);
    check("R8 conv_off in reset", conv_off, 1);
    ext_rst = 1'b0;
    step(EXT);
    check("R3 held minimum", rst_n, 0);
    step(1);
    check("R3 released", rst_n, 1);
    check("R8 conv follows request", conv_off, 0);
  endtask

  task automatic t_watchdog;
    wdog_n = 1'b0; step(1);
    wdog_n = 1'b1;
    check("R5 watchdog sets", failsafe, 1);
    check("R7 tx inhibited", tx_inhibit, 1);
    check("R7 conv shut down", conv_off, 1);
    step(40);
    check("R6 sticky", failsafe, 1);
    check("R7 request ignored", conv_off, 1);
    check("R4 cpu still running", rst_n, 1);
    ext_rst = 1'b1; step(1);
    ext_rst = 1'b0;
    check("R6 ext clears", failsafe, 0);
    check("R7 tx released", tx_inhibit, 0);
    step(EXT + 1);
    check("R3 running again", rst_n, 1);
  endtask

  task automatic t_fs_power_clear;
    wdog_n = 1'b0; step(1);
    wdog_n = 1'b1;
    check("R5 set again", failsafe, 1);
    supply_ok = 1'b0; step(1);
    check("R2 drop asserts reset", rst_n, 0);
    check("R6 supply loss clears", failsafe, 0);
    step(5);
    supply_ok = 1'b1;
    step(S);
    check("R2 stretch restarted", rst_n, 0);
    step(1);
    check("R2 released", rst_n, 1);
  endtask

  task automatic t_wdog_at_release;
    ext_rst = 1'b1; wdog_n = 1'b0; step(1);
    ext_rst = 1'b0;
    step(EXT + 1);
    check("R9 released with strobe low", rst_n, 1);
    check("R9 strobe at release ignored", failsafe, 0);
    wdog_n = 1'b1; step(1);
    check("R9 still clear", failsafe, 0);
  endtask

  task automatic t_sync;
    int hi = 0, per = 0;
    logic prev;
    prev = conv_sync; step(1);
    while (!(conv_sync && !prev)) begin prev = conv_sync; step(1); end
    while (conv_sync) begin hi++; step(1); end
    per = hi;
    while (!conv_sync) begin per++; step(1); end
    check("R10 high time", hi, HALF);
    check("R10 period", per, 2 * HALF);
  endtask

  initial begin
    fork
      begin
        t_powerup();
        t_conv_req();
        t_ext_reset();
        t_watchdog();
        t_fs_power_clear();
        t_wdog_at_release();
        t_sync();
      end
      begin
        step(150_000);
        check("watchdog timeout", 1, 0);
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule